// File: doc/BRIEF.md
# 64-bit Word Single-Error-Correct / Double-Error-Detect Checker

This block guards a 64-bit memory word with an 8-bit check byte. On the write side it computes the check byte from the data word with no clock involved, so it can be stored beside the data. On the read side it takes the returned data, the stored check byte and the access address. It recomputes the check byte and XORs it with the stored byte to form an 8-bit syndrome. From the syndrome it decides whether the word is clean, carries a flipped check bit, carries one flipped data bit (which it inverts back), or is beyond repair.

Each data bit has a code column of weight 3 or 5. Bits 0..55 use the 56 weight-3 byte values in ascending numeric order. Bits 56..63 use the eight smallest weight-5 byte values in ascending order. When a word is beyond repair, the block clears bit 0 and bit 31 of each 32-bit half of the returned word, so a translation-table walk that reads it sees an invalid entry. It also records the failing address in a sticky log that holds the first such address until software pulses a clear. Read results appear one clock after the request.

Top module: `qword_ecc`

## Requirements
- R1: `wr_check` equals the XOR of the code columns of all set bits of `wr_data`. Check bit j is bit j of that XOR. The column of data bit i is the i-th weight-3 byte value in ascending order for i < 56, and the (i-56)-th weight-5 byte value in ascending order for i >= 56.
- R2: `out_valid` is high in exactly the cycle after a cycle with `rd_valid` high. `out_ce` and `out_ue` can only be high in such a cycle.
- R3: A zero syndrome returns the data unchanged with `out_ce` = 0 and `out_ue` = 0.
- R4: A syndrome with exactly one bit set (a flipped check bit) returns the data unchanged with `out_ce` = 1 and `out_ue` = 0.
- R5: A syndrome equal to the column of data bit i inverts bit i of the returned data, with `out_ce` = 1 and `out_ue` = 0.
- R6: A nonzero syndrome of even weight gives `out_ue` = 1 and `out_ce` = 0.
- R7: A syndrome of odd weight 3 or more that matches no data column (for example 0xF8 or 0x7F) gives `out_ue` = 1 and `out_ce` = 0.
- R8: When `out_ue` = 1, `out_data` equals the received data with bits 0, 31, 32 and 63 forced to 0.
- R9: The first uncorrectable read after reset or clear sets `log_valid` and loads `log_addr` from `rd_addr`. Later uncorrectable reads leave `log_addr` unchanged.
- R10: A `log_clr` pulse clears the log (`log_valid` = 0, `log_addr` = 0). If the same cycle carries an uncorrectable valid read, that read's address is loaded instead and `log_valid` stays 1.
- R11: After reset, `out_valid`, `out_ce`, `out_ue`, `out_data` and `log_valid` are all 0.
- R12: Read inputs presented with `rd_valid` low have no effect: `out_data` holds, no flag pulses and the log is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 64 | Data word to be written |
| wr_check | output | 8 | Check byte for `wr_data` |
| rd_valid | input | 1 | Read result present this cycle |
| rd_data | input | 64 | Data word read from memory |
| rd_check | input | 8 | Check byte read from memory |
| rd_addr | input | 32 | Address of the read |
| log_clr | input | 1 | Clear the error log |
| out_valid | output | 1 | Read result valid |
| out_data | output | 64 | Corrected or sanitised data |
| out_ce | output | 1 | Correctable error seen on this result |
| out_ue | output | 1 | Uncorrectable error seen on this result |
| log_valid | output | 1 | Sticky uncorrectable-error flag |
| log_addr | output | 32 | Address of first uncorrectable error |

## Verification
The log clear and the capture of a new uncorrectable address can fall on the same clock edge. The bench provokes this by driving `log_clr` high in the same cycle as a valid read with a double-bit error while an older address is already logged. It then requires `log_addr` to hold the new address with `log_valid` still set. It also checks that an uncorrectable read arriving while the log is full leaves the first address in place.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int N_W3   = 56;

  // Column of data bit idx: weight-3 values ascending, then weight-5 values ascending.
  function automatic logic [CHK_W-1:0] col_of(input int idx);
    logic [CHK_W-1:0] r;
    int n3;
    int n5;
    r  = '0;
    n3 = 0;
    n5 = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      logic [CHK_W-1:0] vb;
      vb = CHK_W'(v);
      if ($countones(vb) == 3) begin
        if (n3 == idx) r = vb;
        n3++;
      end else if ($countones(vb) == 5) begin
        if (n5 + N_W3 == idx) r = vb;
        n5++;
      end
    end
    return r;
  endfunction

  // Data bits that feed check bit j.
  function automatic logic [DATA_W-1:0] row_mask(input int j);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c    = col_of(i);
      m[i] = c[j];
    end
    return m;
  endfunction

  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_CORR  = 2'd1,
    SYN_FATAL = 2'd2
  } syn_class_e;
endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_row
    localparam logic [DATA_W-1:0] MASK = row_mask(j);
    assign check[j] = ^(data & MASK);
  end
endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] fixed_data,
  output syn_class_e        cls
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] KILL_MASK =
    (DATA_W'(1) << 0) | (DATA_W'(1) << (HALF_W - 1)) |
    (DATA_W'(1) << HALF_W) | (DATA_W'(1) << (DATA_W - 1));

  logic [DATA_W-1:0] hit;
  logic [3:0]        wgt;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = col_of(i);
    assign hit[i] = (syn == COL);
  end

  always_comb begin
    wgt        = 4'($countones(syn));
    fixed_data = data;
    cls        = SYN_CLEAN;
    if (wgt == 4'd0) begin
      cls = SYN_CLEAN;
    end else if (wgt == 4'd1) begin
      cls = SYN_CORR;
    end else if (wgt[0] && (|hit)) begin
      cls        = SYN_CORR;
      fixed_data = data ^ hit;
    end else begin
      cls        = SYN_FATAL;
      fixed_data = data & ~KILL_MASK;
    end
  end

  // Distinct columns mean at most one data bit can ever be chosen.
  always_comb begin
    AST_ONE_FLIP: assert ($onehot0(hit)); // R5
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fatal_hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr
);
  logic              valid_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              addr_en;

  always_comb begin
    valid_nxt = log_valid;
    addr_nxt  = log_addr;
    addr_en   = 1'b0;
    if (fatal_hit && (!log_valid || clr)) begin
      valid_nxt = 1'b1;
      addr_nxt  = addr;
      addr_en   = 1'b1;
    end else if (clr) begin
      valid_nxt = 1'b0;
      addr_nxt  = '0;
      addr_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_valid <= 1'b0;
      log_addr  <= '0;
    end else begin
      log_valid <= valid_nxt;
      if (addr_en) log_addr <= addr_nxt;
    end
  end

  AST_LOG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_hit |=> log_valid); // R9
  AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !clr) |=> (log_valid && $stable(log_addr))); // R9
  AST_LOG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fatal_hit) |=> (!log_valid && log_addr == '0)); // R10
endmodule

// File: rtl/qword_ecc.sv
module qword_ecc
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       wr_data,
  output logic [7:0]        wr_check,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  input  logic [7:0]        rd_check,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              log_clr,
  output logic              out_valid,
  output logic [63:0]       out_data,
  output logic              out_ce,
  output logic              out_ue,
  output logic              log_valid,
  output logic [ADDR_W-1:0] log_addr
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ecc_encode u_wr_enc (.data(wr_data), .check(wr_check));

  logic [CHK_W-1:0]  rd_calc;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] fixed_data;
  syn_class_e        cls;

  ecc_encode u_rd_enc (.data(rd_data), .check(rd_calc));
  assign syn = rd_calc ^ rd_check;

  ecc_decode u_dec (
    .data       (rd_data),
    .syn        (syn),
    .fixed_data (fixed_data),
    .cls        (cls)
  );

  logic              valid_nxt;
  logic              ce_nxt;
  logic              ue_nxt;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    valid_nxt = rd_valid;
    ce_nxt    = rd_valid && (cls == SYN_CORR);
    ue_nxt    = rd_valid && (cls == SYN_FATAL);
    data_nxt  = rd_valid ? fixed_data : out_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_ce    <= 1'b0;
      out_ue    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_ce    <= ce_nxt;
      out_ue    <= ue_nxt;
      if (rd_valid) out_data <= data_nxt;
    end
  end

  ecc_err_log #(.ADDR_W(ADDR_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fatal_hit (ue_nxt),
    .addr      (rd_addr),
    .clr       (log_clr),
    .log_valid (log_valid),
    .log_addr  (log_addr)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_valid |=> (!out_valid && !out_ce && !out_ue && $stable(out_data))); // R12
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(out_ce && out_ue)); // R6
  AST_UE_SANITISED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_ue |-> (!out_data[0] && !out_data[31] && !out_data[32] && !out_data[63])); // R8
endmodule

// File: tb/qword_ecc_bench.sv
module qword_ecc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_check = '0;
  logic [31:0] rd_addr = '0;
  logic        log_clr = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_ce;
  logic        out_ue;
  logic        log_valid;
  logic [31:0] log_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [63:0] KILL = 64'h8000_0001_8000_0001;

  always #5 clk = ~clk;

  qword_ecc u_qword_ecc (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
    .rd_addr(rd_addr), .log_clr(log_clr), .out_valid(out_valid),
    .out_data(out_data), .out_ce(out_ce), .out_ue(out_ue),
    .log_valid(log_valid), .log_addr(log_addr)
  );

  // Column table written straight from R1.
  function automatic logic [7:0] bench_col(input int i);
    int k;
    k = 0;
    for (int w = 3; w <= 5; w += 2) begin
      for (int v = 0; v < 256; v++) begin
        if ($countones(8'(v)) == w) begin
          if (k == i) return 8'(v);
          k++;
        end
      end
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] bench_enc(input logic [63:0] d);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= bench_col(i);
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [63:0] d, input logic [7:0] c,
                         input logic [31:0] a, input logic clr);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; rd_check = c; rd_addr = a; log_clr = clr;
    @(negedge clk);
    rd_valid = 1'b0; log_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 out_valid", 64'(out_valid), 0);
    chk("R11 flags", {62'd0, out_ce, out_ue}, 0);
    chk("R11 out_data", out_data, 0);
    chk("R11 log_valid", 64'(log_valid), 0);
  endtask

  task automatic t_encode;
    logic [63:0] pats [4];
    pats[0] = 64'h0; pats[1] = 64'h1; pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h0123_4567_89AB_CDEF;
    for (int p = 0; p < 4; p++) begin
      wr_data = pats[p];
      #1;
      chk("R1 wr_check", 64'(wr_check), 64'(bench_enc(pats[p])));
    end
    wr_data = 64'h8000_0000_0000_0000;
    #1;
    chk("R1 bit63 column", 64'(wr_check), 64'h57);
  endtask

  task automatic t_clean;
    logic [63:0] d;
    d = 64'hDEAD_BEEF_0BAD_F00D;
    do_read(d, bench_enc(d), 32'h100, 1'b0);
    chk("R2 out_valid", 64'(out_valid), 1);
    chk("R3 data", out_data, d);
    chk("R3 flags", {62'd0, out_ce, out_ue}, 0);
    @(negedge clk);
    chk("R2 valid drops", 64'(out_valid), 0);
  endtask

  task automatic t_check_bit;
    logic [63:0] d;
    d = 64'hA5A5_5A5A_FFFF_0000;
    for (int b = 0; b < 8; b += 7) begin
      do_read(d, bench_enc(d) ^ (8'h1 << b), 32'h200, 1'b0);
      chk("R4 data", out_data, d);
      chk("R4 flags ce,ue", {62'd0, out_ce, out_ue}, 64'b10);
    end
  endtask

  task automatic t_data_bit;
    logic [63:0] d;
    int bits [4];
    bits[0] = 0; bits[1] = 31; bits[2] = 40; bits[3] = 63;
    d = 64'h1357_9BDF_2468_ACE0;
    for (int k = 0; k < 4; k++) begin
      do_read(d ^ (64'h1 << bits[k]), bench_enc(d), 32'h300, 1'b0);
      chk("R5 corrected", out_data, d);
      chk("R5 flags ce,ue", {62'd0, out_ce, out_ue}, 64'b10);
    end
  endtask

  task automatic t_double;
    logic [63:0] d, r;
    d = 64'hFFFF_FFFF_FFFF_FFFF;
    r = d ^ 64'h0000_0000_0000_0220;
    do_read(r, bench_enc(d), 32'hCAFE_0001, 1'b0);
    chk("R6 flags ce,ue", {62'd0, out_ce, out_ue}, 64'b01);
    chk("R8 sanitised", out_data, r & ~KILL);
    chk("R9 log_valid", 64'(log_valid), 1);
    chk("R9 log_addr", 64'(log_addr), 64'hCAFE_0001);
  endtask

  task automatic t_odd_nomatch;
    logic [63:0] d;
    d = 64'h0F0F_0F0F_F0F0_F0F0;
    do_read(d, bench_enc(d) ^ 8'hF8, 32'h400, 1'b0);
    chk("R7 flags 0xF8", {62'd0, out_ce, out_ue}, 64'b01);
    chk("R8 sanitised 0xF8", out_data, d & ~KILL);
    do_read(d, bench_enc(d) ^ 8'h7F, 32'h404, 1'b0);
    chk("R7 flags 0x7F", {62'd0, out_ce, out_ue}, 64'b01);
    chk("R9 first addr kept", 64'(log_addr), 64'hCAFE_0001);
  endtask

  task automatic t_clear_collide;
    logic [63:0] d;
    d = 64'h1111_2222_3333_4444;
    do_read(d ^ 64'h3, bench_enc(d), 32'hBEEF_0002, 1'b1);
    chk("R10 collide valid", 64'(log_valid), 1);
    chk("R10 collide addr", 64'(log_addr), 64'hBEEF_0002);
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    chk("R10 cleared valid", 64'(log_valid), 0);
    chk("R10 cleared addr", 64'(log_addr), 0);
    do_read(d ^ 64'hC, bench_enc(d), 32'h0000_0777, 1'b0);
    chk("R9 capture after clear", 64'(log_addr), 64'h777);
  endtask

  task automatic t_idle;
    logic [63:0] d, held;
    d = 64'h5555_AAAA_5555_AAAA;
    do_read(d, bench_enc(d), 32'h500, 1'b0);
    held = out_data;
    @(negedge clk);
    rd_valid = 1'b0; rd_data = d ^ 64'h6; rd_check = bench_enc(d); rd_addr = 32'h999;
    @(negedge clk);
    chk("R12 data held", out_data, held);
    chk("R12 no flags", {61'd0, out_valid, out_ce, out_ue}, 0);
    chk("R12 log unchanged", 64'(log_addr), 64'h777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_encode();
    t_clean();
    t_check_bit();
    t_data_bit();
    t_double();
    t_odd_nomatch();
    t_clear_collide();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule